// File: doc/BRIEF.md
# Weighted Slot-Table Thread Scheduler

This block decides which of several hardware threads owns each execution slot of a time-sliced core. A single 32-bit schedule word holds sixteen 2-bit entries, and each entry names the thread that gets one slot. A slot pointer steps through the entries, one per advance pulse from the core, and wraps after the last one. A thread's share of the core is the number of entries that carry its ID, divided by sixteen. Because the pattern repeats exactly, a thread's slots always fall at the same positions and carry no jitter. A thread whose ID appears in no entry gets no slots at all.

The core writes the schedule word through a simple write strobe. The new word is staged and only becomes active when the pointer wraps from the last entry back to entry 0, so one pass over the table never mixes old and new entries. The outputs are the index of the thread that owns the current slot and a one-hot select. The select is high only while the core advances, and it picks that thread's program counter and flag bank.

Top module: `slot_sched`

## Requirements
- R1: After reset the active and staged tables are all zeros, the pointer is at entry 0, `thr_id` is 0 and `thr_sel` is 0 while `adv` is low.
- R2: Each cycle with `adv` high moves the pointer up by one entry. A cycle with `adv` low leaves it unchanged.
- R3: An advance taken while the pointer is at entry 15 returns the pointer to entry 0.
- R4: While the pointer is at entry k, `thr_id` equals bits [2k+1:2k] of the active table. Entry 0 sits in bits 1:0 and entry 15 sits in bits 31:30.
- R5: Over any 16 consecutive advances that begin at entry 0, each thread owns as many slots as the entries that hold its ID. A thread whose ID is absent owns none.
- R6: A word written with `cfg_we` is loaded into the active table by the first wrap that follows the write cycle. A write made in the same cycle as a wrap waits for the next wrap. Until that load, `thr_id` keeps following the old table.
- R7: `thr_sel` has exactly one bit set, bit `thr_id`, while `adv` is high. It is all zeros while `adv` is low.
- R8: A thread placed in every odd entry gets 8 of 16 slots, and its slots are always exactly two advances apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the staged schedule word |
| cfg_wdata | input | 32 | Schedule word, with entry k in bits [2k+1:2k] |
| adv | input | 1 | Slot advance pulse from the core |
| thr_id | output | 2 | Thread that owns the current slot |
| thr_sel | output | 4 | One-hot select of the context bank, gated by `adv` |

## Verification
A table with alternating thread IDs shows the fixed two-slot spacing and the eight-slot share, and it confirms that an absent thread gets nothing. Writes made in the middle of a pass, and a write made in the same cycle as a wrap, separate a correct deferred load from a load that happens early or one wrap late. Long random runs mix random words, random write timing and random gaps in `adv`, so an off-by-one pointer step or a wrong bit order in an entry shows up as a mismatch against the bench model.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;
   localparam int unsigned DEF_THREADS = 4;
   localparam int unsigned DEF_ENTRIES = 16;

   function automatic bit is_pow2(input int unsigned v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/slot_sched_ptr.sv
module slot_sched_ptr #(
   parameter int unsigned NUM_ENTRIES = slot_sched_pkg::DEF_ENTRIES,
   localparam int unsigned PTR_W = $clog2(NUM_ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [PTR_W-1:0] ptr,
   output logic             wrap
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_ENTRIES - 1);

   assign wrap = adv && (ptr == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr <= '0;
      else if (adv)
         ptr <= (ptr == LAST) ? '0 : ptr + PTR_W'(1);
   end

   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && ptr != LAST) |=> (ptr == $past(ptr) + PTR_W'(1)));
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(ptr));
   a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (ptr == '0));
endmodule

// File: rtl/slot_sched_table.sv
module slot_sched_table #(
   parameter int unsigned TBL_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [TBL_W-1:0] cfg_wdata,
   input  logic             wrap,
   output logic [TBL_W-1:0] active
);
   logic [TBL_W-1:0] staged;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         staged <= '0;
         active <= '0;
      end else begin
         if (cfg_we) staged <= cfg_wdata;
         if (wrap)   active <= staged;
      end
   end

   a_r6_no_early_load: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(active));
endmodule

// File: rtl/slot_sched_decode.sv
module slot_sched_decode #(
   parameter int unsigned NUM_THREADS = slot_sched_pkg::DEF_THREADS,
   parameter int unsigned NUM_ENTRIES = slot_sched_pkg::DEF_ENTRIES,
   localparam int unsigned ID_W  = $clog2(NUM_THREADS),
   localparam int unsigned PTR_W = $clog2(NUM_ENTRIES),
   localparam int unsigned TBL_W = NUM_ENTRIES * ID_W
) (
   input  logic [TBL_W-1:0]       active,
   input  logic [PTR_W-1:0]       ptr,
   input  logic                   adv,
   output logic [ID_W-1:0]        thr_id,
   output logic [NUM_THREADS-1:0] thr_sel
);
   logic [ID_W-1:0] entry [NUM_ENTRIES];

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
      assign entry[e] = active[e*ID_W +: ID_W];
   end

   assign thr_id = entry[ptr];

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_sel
      assign thr_sel[t] = adv && (thr_id == ID_W'(t));
   end
endmodule

// File: rtl/slot_sched.sv
module slot_sched #(
   parameter int unsigned NUM_THREADS = slot_sched_pkg::DEF_THREADS,
   parameter int unsigned NUM_ENTRIES = slot_sched_pkg::DEF_ENTRIES,
   localparam int unsigned ID_W  = $clog2(NUM_THREADS),
   localparam int unsigned PTR_W = $clog2(NUM_ENTRIES),
   localparam int unsigned TBL_W = NUM_ENTRIES * ID_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [TBL_W-1:0]       cfg_wdata,
   input  logic                   adv,
   output logic [ID_W-1:0]        thr_id,
   output logic [NUM_THREADS-1:0] thr_sel
);
   if (!slot_sched_pkg::is_pow2(NUM_THREADS)) begin : g_bad_threads
      $error("NUM_THREADS must be a power of two, 2 or more");
   end
   if (!slot_sched_pkg::is_pow2(NUM_ENTRIES)) begin : g_bad_entries
      $error("NUM_ENTRIES must be a power of two, 2 or more");
   end

   logic [PTR_W-1:0] ptr;
   logic             wrap;
   logic [TBL_W-1:0] active;

   slot_sched_ptr #(.NUM_ENTRIES(NUM_ENTRIES)) u_ptr (
      .clk(clk), .rst_n(rst_n), .adv(adv), .ptr(ptr), .wrap(wrap));

   slot_sched_table #(.TBL_W(TBL_W)) u_tbl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .wrap(wrap), .active(active));

   slot_sched_decode #(.NUM_THREADS(NUM_THREADS), .NUM_ENTRIES(NUM_ENTRIES)) u_dec (
      .active(active), .ptr(ptr), .adv(adv), .thr_id(thr_id), .thr_sel(thr_sel));

   a_r7_sel_one: assert property (@(posedge clk) disable iff (!rst_n)
      adv |-> ($countones(thr_sel) == 1 && thr_sel[thr_id]));
   a_r7_sel_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |-> (thr_sel == '0));
   a_r1_reset_id: assert property (@(posedge clk)
      !rst_n |=> (thr_id == '0));
endmodule

// File: tb/tb_slot_sched.sv
module tb_slot_sched;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        adv = 1'b0;
   logic [1:0]  thr_id;
   logic [3:0]  thr_sel;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [31:0] m_act, m_stg;
   int          m_ptr;
   logic [1:0]  last_id;

   always #2 clk = ~clk;

   slot_sched dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
                   .adv(adv), .thr_id(thr_id), .thr_sel(thr_sel));

   function automatic logic [1:0] exp_id(input logic [31:0] t, input int p);
      return t[2*p +: 2];
   endfunction

   function automatic logic [3:0] exp_sel(input logic [1:0] id, input logic a);
      return a ? (4'b0001 << id) : 4'b0000;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input logic we, input logic [31:0] d, input logic a);
      @(negedge clk);
      cfg_we = we; cfg_wdata = d; adv = a;
      #1;
      chk("R4", thr_id, exp_id(m_act, m_ptr));
      chk("R7", thr_sel, exp_sel(exp_id(m_act, m_ptr), a));
      last_id = thr_id;
      @(posedge clk);
      if (a) begin
         if (m_ptr == 15) begin m_ptr = 0; m_act = m_stg; end
         else m_ptr++;
      end
      if (we) m_stg = d;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; cfg_we = 0; adv = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      m_act = '0; m_stg = '0; m_ptr = 0;
   endtask

   initial begin
      #700000;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int cnt[4];
      int lastpos;
      void'($urandom(32'h5EED_1234));
      do_reset();
      #1;
      chk("R1 id", thr_id, 0);
      chk("R1 sel", thr_sel, 0);

      // R6: write mid-pass, old table keeps ruling until wrap
      step(1'b0, '0, 1'b1);
      step(1'b1, 32'h6464_6464, 1'b1);
      for (int i = 0; i < 14; i++) begin
         step(1'b0, '0, 1'b1);
         chk("R6 old table", last_id, 0);
      end
      // R5, R8: one full pass on new table
      foreach (cnt[k]) cnt[k] = 0;
      lastpos = -1;
      for (int i = 0; i < 16; i++) begin
         step(1'b0, '0, (i % 3) != 2 ? 1'b1 : 1'b1);
         cnt[last_id]++;
         if (last_id == 2'd1) begin
            if (lastpos >= 0) chk("R8 spacing", i - lastpos, 2);
            lastpos = i;
         end
      end
      chk("R5 t0", cnt[0], 4);
      chk("R8 t1", cnt[1], 8);
      chk("R5 t2", cnt[2], 4);
      chk("R5 t3 absent", cnt[3], 0);

      // R2: idle cycles hold pointer; R3 wrap
      for (int i = 0; i < 5; i++) step(1'b0, '0, 1'b0);
      for (int i = 0; i < 15; i++) step(1'b0, '0, 1'b1);
      // R6: write in the wrap cycle waits one more pass
      step(1'b1, 32'hFFFF_FFFF, 1'b1);
      chk("R3 wrapped id", m_ptr, 0);
      for (int i = 0; i < 16; i++) begin
         step(1'b0, '0, 1'b1);
         chk("R6 same-cycle write deferred", last_id, exp_id(32'h6464_6464, i));
      end
      step(1'b0, '0, 1'b1);
      chk("R6 loaded", last_id, 3);

      // random mix
      for (int i = 0; i < 4000; i++)
         step(($urandom % 8) == 0, $urandom, ($urandom % 4) != 0);

      // R1: reset mid-run
      do_reset();
      #1;
      chk("R1 id after reset", thr_id, 0);
      for (int i = 0; i < 20; i++) begin
         step(1'b0, '0, 1'b1);
         chk("R1 zero table", last_id, 0);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule